// File: doc/BRIEF.md
# Status Word and Bulk-Command Guard

This block sits behind a serial command decoder in a small nonvolatile memory. It keeps an 8-bit status word up to date and gates the two whole-array commands, bulk erase and bulk write. Neither command reaches the program timer until a second, confirming strobe has arrived. The decoder gives it single-cycle strobes for each command it recognises. The program timer gives it a level busy flag. The block answers with one-cycle go pulses for the timer and a status word. It also drives a data-out pin with an output enable, so that a host polling the serial line can see the busy state.

The block moves no data stream, so there is no valid/ready interface. Every strobe is a plain pulse with no back-pressure: the decoder may issue a command in any cycle, and the block acts on it in that cycle. A go pulse is advisory to the timer and is never held.

Top module: `bulk_guard_status`

## Requirements
- R1: Status bits [7:5] always read 1,0,1 and bits [1:0] always read 0.
- R2: Status bit 4 is the parity-error flag, bit 3 the instruction-error flag, and bit 2 equals `prog_busy` in the same cycle (1 = busy).
- R3: The error flags are sticky. They clear in the cycle after a `cmd_stat_rd` strobe. An error raised in the same cycle as the read wins, and its flag stays set.
- R4: A first `cmd_erase_all` only arms the guard. A second, consecutive `cmd_erase_all` raises `go_erase_all` for one cycle, starting the cycle after the strobe, and disarms the guard.
- R5: A `cmd_write_all` arriving while the guard is armed raises `go_write_all` for one cycle, starting the cycle after the strobe. It does not raise `go_erase_all`.
- R6: Any other command strobe (`cmd_other`, `cmd_busy_en`, `cmd_stat_rd`) disarms the guard.
- R7: A `cmd_write_all` arriving while the guard is not armed sets the instruction-error flag and produces no go pulse.
- R8: A bulk command arriving while `prog_busy` is high sets the instruction-error flag, disarms the guard and produces no go pulse.
- R9: Until `cmd_busy_en` has been seen, `dout_oe` stays low.
- R10: After `cmd_busy_en`, while `prog_busy` is high, `dout_oe` is 1 and `dout` is 0.
- R11: After `cmd_busy_en`, once `prog_busy` falls, `dout_oe` stays 1 with `dout` at 1 until a `cs_start` pulse releases the pin.
- R12: In reset, the status word reads 8'hA0, both go outputs are 0 and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_start | input | 1 | Pulse at the start of a new chip-select frame |
| cmd_erase_all | input | 1 | Decoded bulk-erase strobe |
| cmd_write_all | input | 1 | Decoded bulk-write strobe |
| cmd_busy_en | input | 1 | Strobe that turns on busy reporting on data-out |
| cmd_other | input | 1 | Strobe for any other decoded command |
| cmd_stat_rd | input | 1 | Status-read strobe; clears the error flags |
| parity_err_in | input | 1 | Parity-error event pulse |
| instr_err_in | input | 1 | Instruction-error event pulse from the decoder |
| prog_busy | input | 1 | Program or erase cycle in progress |
| status_word | output | 8 | Status word |
| go_erase_all | output | 1 | One-cycle start pulse for bulk erase |
| go_write_all | output | 1 | One-cycle start pulse for bulk write |
| dout | output | 1 | Data-out value reporting busy (0) or ready (1) |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The assertions assume the decoder raises at most one of the five command strobes in any cycle. They also assume `prog_busy` is a clean level from the timer, which may change in any cycle. The bench drives only one strobe per cycle, including in its pseudo-random phase, where it chooses at most one command per cycle. Busy pulses of varied length are mixed with `cs_start` pulses and error events, including bulk commands issued while busy and status reads that coincide with new errors.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int STATUS_W   = 8;
  localparam int SIG_W      = 3;
  localparam int RSVD_W     = 2;
  localparam logic [SIG_W-1:0] SIG_PATTERN = 3'b101;

  typedef enum logic { ARM_IDLE = 1'b0, ARM_SET = 1'b1 } arm_e;

  typedef struct packed {
    logic [SIG_W-1:0]  sig;
    logic              perr;
    logic              ierr;
    logic              busy;
    logic [RSVD_W-1:0] rsvd;
  } status_t;
endpackage

// File: rtl/bgs_arm_ctl.sv
module bgs_arm_ctl
  import bgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_erase,
  input  logic cmd_write,
  input  logic cmd_clr,
  input  logic prog_busy,
  output logic go_erase,
  output logic go_write,
  output logic seq_err
);
  arm_e arm_q, arm_d;
  logic ge_d, gw_d;

  always_comb begin
    arm_d   = arm_q;
    ge_d    = 1'b0;
    gw_d    = 1'b0;
    seq_err = 1'b0;
    if (cmd_erase) begin
      if (prog_busy) begin
        seq_err = 1'b1;
        arm_d   = ARM_IDLE;
      end else if (arm_q == ARM_SET) begin
        ge_d  = 1'b1;
        arm_d = ARM_IDLE;
      end else begin
        arm_d = ARM_SET;
      end
    end else if (cmd_write) begin
      if (prog_busy) begin
        seq_err = 1'b1;
        arm_d   = ARM_IDLE;
      end else if (arm_q == ARM_SET) begin
        gw_d  = 1'b1;
        arm_d = ARM_IDLE;
      end else begin
        seq_err = 1'b1;
      end
    end else if (cmd_clr) begin
      arm_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= ARM_IDLE;
      go_erase <= 1'b0;
      go_write <= 1'b0;
    end else begin
      arm_q    <= arm_d;
      go_erase <= ge_d;
      go_write <= gw_d;
    end
  end

  AST_ERASE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go_erase |-> ($past(cmd_erase) && $past(arm_q) == ARM_SET)); // R4
  AST_WRITE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go_write |-> ($past(cmd_write) && $past(arm_q) == ARM_SET && !go_erase)); // R5
  AST_CLR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !cmd_erase && !cmd_write) |=> (arm_q == ARM_IDLE)); // R6
  AST_BUSY_NOGO: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && (cmd_erase || cmd_write)) |=> (!go_erase && !go_write)); // R8
endmodule

// File: rtl/bgs_stat_reg.sv
module bgs_stat_reg
  import bgs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                perr_set,
  input  logic                ierr_set,
  input  logic                rd_clr,
  input  logic                prog_busy,
  output logic [STATUS_W-1:0] status_word
);
  logic perr_q, ierr_q;
  status_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      ierr_q <= 1'b0;
    end else begin
      perr_q <= perr_set | (perr_q & ~rd_clr);
      ierr_q <= ierr_set | (ierr_q & ~rd_clr);
    end
  end

  always_comb begin
    st.sig  = SIG_PATTERN;
    st.perr = perr_q;
    st.ierr = ierr_q;
    st.busy = prog_busy;
    st.rsvd = '0;
  end

  assign status_word = st;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !rd_clr) |=> perr_q); // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !ierr_set) |=> !ierr_q); // R3
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ierr_set |=> ierr_q); // R7
endmodule

// File: rtl/bgs_busy_pin.sv
module bgs_busy_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_en_cmd,
  input  logic cs_start,
  input  logic prog_busy,
  output logic dout,
  output logic dout_oe
);
  logic en_q, busy_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (busy_en_cmd) en_q <= 1'b1;
      busy_q <= prog_busy;
      if (busy_q && !prog_busy && en_q) hold_q <= 1'b1;
      else if (cs_start || prog_busy)   hold_q <= 1'b0;
    end
  end

  assign dout_oe = en_q & (prog_busy | busy_q | hold_q);
  assign dout    = ~prog_busy;

  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !dout_oe); // R9
  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && prog_busy) |-> (dout_oe && !dout)); // R10
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && !prog_busy && !cs_start && !busy_en_cmd) |=> (prog_busy || (dout_oe && dout))); // R11
endmodule

// File: rtl/bulk_guard_status.sv
module bulk_guard_status
  import bgs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_start,
  input  logic                cmd_erase_all,
  input  logic                cmd_write_all,
  input  logic                cmd_busy_en,
  input  logic                cmd_other,
  input  logic                cmd_stat_rd,
  input  logic                parity_err_in,
  input  logic                instr_err_in,
  input  logic                prog_busy,
  output logic [STATUS_W-1:0] status_word,
  output logic                go_erase_all,
  output logic                go_write_all,
  output logic                dout,
  output logic                dout_oe
);
  logic cmd_clr, seq_err;

  assign cmd_clr = cmd_other | cmd_busy_en | cmd_stat_rd;

  bgs_arm_ctl u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_erase (cmd_erase_all),
    .cmd_write (cmd_write_all),
    .cmd_clr   (cmd_clr),
    .prog_busy (prog_busy),
    .go_erase  (go_erase_all),
    .go_write  (go_write_all),
    .seq_err   (seq_err)
  );

  bgs_stat_reg u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .perr_set    (parity_err_in),
    .ierr_set    (instr_err_in | seq_err),
    .rd_clr      (cmd_stat_rd),
    .prog_busy   (prog_busy),
    .status_word (status_word)
  );

  bgs_busy_pin u_pin (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_en_cmd (cmd_busy_en),
    .cs_start    (cs_start),
    .prog_busy   (prog_busy),
    .dout        (dout),
    .dout_oe     (dout_oe)
  );

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_erase_all, cmd_write_all, cmd_busy_en, cmd_other, cmd_stat_rd})); // R6
  AST_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_erase_all && go_write_all)); // R5
endmodule

// File: tb/sim_bulk_guard_status.sv
`timescale 1ns/1ps
module sim_bulk_guard_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_start = 0, c_er = 0, c_wr = 0, c_be = 0, c_ot = 0, c_rd = 0;
  logic pe_in = 0, ie_in = 0, busy = 0;
  logic [7:0] status_word;
  logic go_e, go_w, dout, dout_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  bit m_arm, m_perr, m_ierr, m_en, m_bq, m_hold, m_ge, m_gw;

  always #2 clk = ~clk;

  bulk_guard_status u0 (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start),
    .cmd_erase_all(c_er), .cmd_write_all(c_wr), .cmd_busy_en(c_be),
    .cmd_other(c_ot), .cmd_stat_rd(c_rd), .parity_err_in(pe_in),
    .instr_err_in(ie_in), .prog_busy(busy), .status_word(status_word),
    .go_erase_all(go_e), .go_write_all(go_w), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_arm = 0; m_perr = 0; m_ierr = 0; m_en = 0;
    m_bq = 0; m_hold = 0; m_ge = 0; m_gw = 0;
  endtask

  task automatic model_step();
    bit n_arm, n_perr, n_ierr, n_hold;
    n_arm = m_arm; n_perr = m_perr; n_ierr = m_ierr;
    m_ge = 0; m_gw = 0;
    if (c_rd) begin n_perr = 0; n_ierr = 0; end
    if (pe_in) n_perr = 1;
    if (ie_in) n_ierr = 1;
    if (c_er) begin
      if (busy) begin n_ierr = 1; n_arm = 0; end
      else if (m_arm) begin m_ge = 1; n_arm = 0; end
      else n_arm = 1;
    end else if (c_wr) begin
      if (busy) begin n_ierr = 1; n_arm = 0; end
      else if (m_arm) begin m_gw = 1; n_arm = 0; end
      else n_ierr = 1;
    end else if (c_be || c_ot || c_rd) n_arm = 0;
    if (m_bq && !busy && m_en) n_hold = 1;
    else if (cs_start || busy) n_hold = 0;
    else n_hold = m_hold;
    if (c_be) m_en = 1;
    m_bq = busy;
    m_arm = n_arm; m_perr = n_perr; m_ierr = n_ierr; m_hold = n_hold;
  endtask

  task automatic compare_all();
    bit exp_oe;
    exp_oe = m_en && (busy || m_bq || m_hold);
    chk("R1 fixed bits", {3'b0, status_word[7:5], status_word[1:0]}, {3'b0, 3'b101, 2'b00});
    chk("R2 busy bit", {7'b0, status_word[2]}, {7'b0, busy});
    chk("R2/R3 error bits", {6'b0, status_word[4:3]}, {6'b0, m_perr, m_ierr});
    chk("R4 go_erase_all", {7'b0, go_e}, {7'b0, m_ge});
    chk("R5 go_write_all", {7'b0, go_w}, {7'b0, m_gw});
    chk("R9/R10/R11 dout_oe", {7'b0, dout_oe}, {7'b0, exp_oe});
    if (exp_oe) chk("R10/R11 dout", {7'b0, dout}, {7'b0, !busy});
  endtask

  task automatic step(input bit er, wr, be, ot, rd, cs, pe, ie, bz);
    @(negedge clk);
    c_er = er; c_wr = wr; c_be = be; c_ot = ot; c_rd = rd;
    cs_start = cs; pe_in = pe; ie_in = ie; busy = bz;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic idle(input int n, input bit bz);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0,bz);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 status in reset", status_word, 8'hA0);
    chk("R12 go in reset", {6'b0, go_e, go_w}, 8'h00);
    chk("R12 oe in reset", {7'b0, dout_oe}, 8'h00);
    rst_n = 1'b1;
    idle(2, 0);
    // R4: double erase
    step(1,0,0,0,0,0,0,0,0);
    chk("R4 no go after first erase", {7'b0, go_e}, 8'h00);
    step(1,0,0,0,0,0,0,0,0);
    idle(2, 0);
    // R6: intervening command disarms
    step(1,0,0,0,0,0,0,0,0);
    step(0,0,0,1,0,0,0,0,0);
    step(1,0,0,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0,0,0);
    // R5: erase then write
    step(1,0,0,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0,0);
    idle(1, 0);
    // R7: write without arm; R3 read clears
    step(0,1,0,0,0,0,0,0,0);
    idle(3, 0);
    step(0,0,0,0,1,0,0,0,0);
    idle(1, 0);
    // R3: parity sticky, read with concurrent error
    step(0,0,0,0,0,0,1,0,0);
    idle(3, 0);
    step(0,0,0,0,1,0,1,0,0);
    step(0,0,0,0,1,0,0,0,0);
    // R9: busy without enable; R8: bulk cmds while busy
    idle(2, 1);
    step(1,0,0,0,0,0,0,0,1);
    step(1,0,0,0,0,0,0,0,1);
    step(0,1,0,0,0,0,0,0,1);
    idle(3, 0);
    step(0,0,0,0,1,0,0,0,0);
    // R8: armed, then erase while busy disarms
    step(1,0,0,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0,0,1);
    step(1,0,0,0,0,0,0,0,0);
    // R10/R11: enable, busy, release on cs_start
    step(0,0,1,0,0,0,0,0,0);
    idle(4, 1);
    idle(4, 0);
    step(0,0,0,0,0,1,0,0,0);
    idle(2, 0);
    // R6: busy-enable between erases disarms
    step(1,0,0,0,0,0,0,0,0);
    step(0,0,1,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0,0,0);
    // mixed pseudo-random phase, one strobe per cycle
    begin
      int lfsr = 32'h1ACE5;
      bit bz = 0;
      for (int i = 0; i < 3000; i++) begin
        int sel;
        lfsr = (lfsr << 1) ^ ((lfsr >>> 31) & 1 ? 32'h04C11DB7 : 0) ^ i;
        sel = (lfsr >> 3) & 15;
        if (((lfsr >> 9) & 7) == 0) bz = !bz;
        step(sel == 0 || sel == 1 || sel == 2, sel == 3 || sel == 4, sel == 5,
             sel == 6, sel == 7, ((lfsr >> 13) & 7) == 0,
             ((lfsr >> 17) & 15) == 0, ((lfsr >> 21) & 15) == 0, bz);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule